// File: doc/BRIEF.md
# AXI4 Burst Latency Profiler

This block sits beside one AXI4 manager port and watches both the write and the read channels without driving any of them. During each sampling interval it sums the bytes moved, the address handshakes issued, the bursts completed, and the cycles spent in three phases of every burst. The first phase is the wait from address handshake to first data beat, which covers arbitration and interconnect delay. The second phase is the data run from the first beat to the last beat. The third phase is the write tail, from the last beat to the response.

A host pulses `snap_i` to close an interval. In that one cycle every accumulator is copied into a readable shadow register and restarts from the events of that same cycle, so no event falls between the read and the clear. The host selects a shadow register with `reg_addr_i`. It forms an average latency by dividing a phase sum by the completed-burst count.

All accumulators are `ACC_W` bits wide and saturate at their maximum. A saturation in an interval raises a sticky flag that travels with that interval's snapshot, which marks the sample as untrustworthy. Each direction carries at most one burst at a time, and data beats are expected strictly after their address handshake.

Top module: `axi_burst_prof`

## Requirements
- R1: After reset, every register address reads zero until the first snapshot.
- R2: Each data handshake (valid and ready high while a burst is open) adds 2^size bytes to the byte sum at address 0, where size is the 3-bit AxSIZE captured at that burst's address handshake. This applies to both reads and writes.
- R3: Each AW or AR handshake adds one to the request count at address 1. An AW and an AR handshake in the same cycle add two.
- R4: The completed-burst count at address 5 increments on the R beat with last set for a read, and on the B handshake for a write.
- R5: The phase-one sum at address 2 gains, per completed burst, the number of cycles from the address handshake to the first data handshake.
- R6: The phase-two sum at address 3 gains, per completed burst, the number of cycles from the first to the last data handshake. A single-beat burst adds zero.
- R7: The phase-three sum at address 4 gains, per completed write, the number of cycles from the last W handshake to the B handshake. A read adds zero.
- R8: In the cycle `snap_i` is high, the accumulators are copied to the shadow registers and cleared. Events in that same cycle are counted in the new interval. The shadow registers do not change until the next snapshot.
- R9: An accumulator whose sum would exceed 2^ACC_W-1 holds that maximum and sets the overflow bit, bit 0 of address 6, in that interval's snapshot. The next interval starts with the bit clear.
- R10: A valid without its ready on any channel changes no sum.
- R11: Address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aw_valid_i | input | 1 | Observed write address valid |
| aw_ready_i | input | 1 | Observed write address ready |
| aw_size_i | input | 3 | Observed write beat size (log2 bytes) |
| w_valid_i | input | 1 | Observed write data valid |
| w_ready_i | input | 1 | Observed write data ready |
| w_last_i | input | 1 | Observed write last beat |
| b_valid_i | input | 1 | Observed write response valid |
| b_ready_i | input | 1 | Observed write response ready |
| ar_valid_i | input | 1 | Observed read address valid |
| ar_ready_i | input | 1 | Observed read address ready |
| ar_size_i | input | 3 | Observed read beat size (log2 bytes) |
| r_valid_i | input | 1 | Observed read data valid |
| r_ready_i | input | 1 | Observed read data ready |
| r_last_i | input | 1 | Observed read last beat |
| snap_i | input | 1 | Snapshot and clear strobe |
| reg_addr_i | input | 3 | Shadow register select |
| reg_rdata_o | output | ACC_W | Selected shadow register |

## Verification
Two situations are hard to reach from the ports. The first is a snapshot that lands on the very beat that completes a read: the stimulus raises `snap_i` in the cycle of the last R beat, then checks that the old interval holds the request and first beat while the new one holds the completion and its latencies. The second is saturation, which a 32-bit sum cannot reach in a short run. The bench therefore builds the block with 8-bit accumulators and drives a two-beat read of 128-byte beats, which pushes the byte sum past its limit. Around these, a sweep covers beat size, beat count, first-beat delay and response delay in both directions, and idles stall cycles with valid held and ready low.

// File: rtl/prof_pkg.sv
package prof_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_BURST,
    ST_RESP
  } chan_state_e;

  localparam int NUM_ACC   = 6;
  localparam int ACC_BYTES = 0;
  localparam int ACC_REQ   = 1;
  localparam int ACC_LAT1  = 2;
  localparam int ACC_LAT2  = 3;
  localparam int ACC_LAT3  = 4;
  localparam int ACC_DONE  = 5;
  localparam int ADDR_STAT = 6;
  localparam int NUM_REG   = 8;
endpackage

// File: rtl/prof_chan.sv
module prof_chan
  import prof_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit HAS_RESP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_valid_i,
  input  logic             a_ready_i,
  input  logic [2:0]       a_size_i,
  input  logic             d_valid_i,
  input  logic             d_ready_i,
  input  logic             d_last_i,
  input  logic             resp_valid_i,
  input  logic             resp_ready_i,
  output logic             req_o,
  output logic             done_o,
  output logic [CNT_W-1:0] lat1_o,
  output logic [CNT_W-1:0] lat2_o,
  output logic [CNT_W-1:0] lat3_o,
  output logic [CNT_W-1:0] bytes_o
);
  chan_state_e      state_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc, lat1_q, lat2_q;
  logic [2:0]       size_q;
  logic             a_hs, d_hs, r_hs, open;

  assign a_hs    = a_valid_i & a_ready_i;
  assign open    = (state_q == ST_FIRST) || (state_q == ST_BURST);
  assign d_hs    = d_valid_i & d_ready_i & open;
  assign r_hs    = resp_valid_i & resp_ready_i & (state_q == ST_RESP);
  assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(1);
  assign req_o   = a_hs;
  assign bytes_o = d_hs ? (CNT_W'(1) << size_q) : '0;

  always_comb begin
    done_o = 1'b0;
    lat1_o = '0;
    lat2_o = '0;
    lat3_o = '0;
    unique case (state_q)
      ST_FIRST: if (d_hs && d_last_i && !HAS_RESP) begin
        done_o = 1'b1;
        lat1_o = cnt_inc;
      end
      ST_BURST: if (d_hs && d_last_i && !HAS_RESP) begin
        done_o = 1'b1;
        lat1_o = lat1_q;
        lat2_o = cnt_inc;
      end
      ST_RESP: if (r_hs) begin
        done_o = 1'b1;
        lat1_o = lat1_q;
        lat2_o = lat2_q;
        lat3_o = cnt_inc;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      size_q  <= '0;
      lat1_q  <= '0;
      lat2_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (a_hs) begin
          state_q <= ST_FIRST;
          cnt_q   <= '0;
          size_q  <= a_size_i;
        end
        ST_FIRST: if (d_hs) begin
          lat1_q <= cnt_inc;
          cnt_q  <= '0;
          if (d_last_i) begin
            lat2_q  <= '0;
            state_q <= HAS_RESP ? ST_RESP : ST_IDLE;
          end else begin
            state_q <= ST_BURST;
          end
        end else begin
          cnt_q <= cnt_inc;
        end
        ST_BURST: if (d_hs && d_last_i) begin
          lat2_q  <= cnt_inc;
          cnt_q   <= '0;
          state_q <= HAS_RESP ? ST_RESP : ST_IDLE;
        end else begin
          cnt_q <= cnt_inc;
        end
        ST_RESP: if (r_hs) begin
          state_q <= ST_IDLE;
        end else begin
          cnt_q <= cnt_inc;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prof_acc.sv
module prof_acc #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] inc_a_i,
  input  logic [W-1:0] inc_b_i,
  output logic [W-1:0] acc_o,
  output logic         ov_o
);
  logic [W-1:0] acc_q;
  logic [W+1:0] sum;

  always_comb begin
    sum  = (clr_i ? '0 : {2'b00, acc_q}) + {2'b00, inc_a_i} + {2'b00, inc_b_i};
    ov_o = |sum[W+1:W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (ov_o) acc_q <= '1;
    else           acc_q <= sum[W-1:0];
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/axi_burst_prof.sv
module axi_burst_prof
  import prof_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             aw_valid_i,
  input  logic             aw_ready_i,
  input  logic [2:0]       aw_size_i,
  input  logic             w_valid_i,
  input  logic             w_ready_i,
  input  logic             w_last_i,
  input  logic             b_valid_i,
  input  logic             b_ready_i,
  input  logic             ar_valid_i,
  input  logic             ar_ready_i,
  input  logic [2:0]       ar_size_i,
  input  logic             r_valid_i,
  input  logic             r_ready_i,
  input  logic             r_last_i,
  input  logic             snap_i,
  input  logic [2:0]       reg_addr_i,
  output logic [ACC_W-1:0] reg_rdata_o
);
  logic             wr_req, wr_done, rd_req, rd_done;
  logic [ACC_W-1:0] wr_lat1, wr_lat2, wr_lat3, wr_bytes;
  logic [ACC_W-1:0] rd_lat1, rd_lat2, rd_lat3, rd_bytes;

  prof_chan #(.CNT_W(ACC_W), .HAS_RESP(1'b1)) u_wr (
    .clk_i, .rst_ni,
    .a_valid_i(aw_valid_i), .a_ready_i(aw_ready_i), .a_size_i(aw_size_i),
    .d_valid_i(w_valid_i), .d_ready_i(w_ready_i), .d_last_i(w_last_i),
    .resp_valid_i(b_valid_i), .resp_ready_i(b_ready_i),
    .req_o(wr_req), .done_o(wr_done),
    .lat1_o(wr_lat1), .lat2_o(wr_lat2), .lat3_o(wr_lat3), .bytes_o(wr_bytes)
  );

  prof_chan #(.CNT_W(ACC_W), .HAS_RESP(1'b0)) u_rd (
    .clk_i, .rst_ni,
    .a_valid_i(ar_valid_i), .a_ready_i(ar_ready_i), .a_size_i(ar_size_i),
    .d_valid_i(r_valid_i), .d_ready_i(r_ready_i), .d_last_i(r_last_i),
    .resp_valid_i(1'b0), .resp_ready_i(1'b0),
    .req_o(rd_req), .done_o(rd_done),
    .lat1_o(rd_lat1), .lat2_o(rd_lat2), .lat3_o(rd_lat3), .bytes_o(rd_bytes)
  );

  logic [ACC_W-1:0] inc_wr [NUM_ACC];
  logic [ACC_W-1:0] inc_rd [NUM_ACC];
  logic [ACC_W-1:0] acc_q  [NUM_ACC];
  logic [ACC_W-1:0] shadow_q [NUM_ACC];
  logic [NUM_ACC-1:0] ov_now;
  logic ov_q, ov_shadow_q;
  logic [ACC_W-1:0] bytes_acc;

  always_comb begin
    inc_wr[ACC_BYTES] = wr_bytes;
    inc_wr[ACC_REQ]   = {{(ACC_W-1){1'b0}}, wr_req};
    inc_wr[ACC_LAT1]  = wr_lat1;
    inc_wr[ACC_LAT2]  = wr_lat2;
    inc_wr[ACC_LAT3]  = wr_lat3;
    inc_wr[ACC_DONE]  = {{(ACC_W-1){1'b0}}, wr_done};
    inc_rd[ACC_BYTES] = rd_bytes;
    inc_rd[ACC_REQ]   = {{(ACC_W-1){1'b0}}, rd_req};
    inc_rd[ACC_LAT1]  = rd_lat1;
    inc_rd[ACC_LAT2]  = rd_lat2;
    inc_rd[ACC_LAT3]  = rd_lat3;
    inc_rd[ACC_DONE]  = {{(ACC_W-1){1'b0}}, rd_done};
  end

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    prof_acc #(.W(ACC_W)) u_acc (
      .clk_i, .rst_ni,
      .clr_i(snap_i),
      .inc_a_i(inc_wr[i]),
      .inc_b_i(inc_rd[i]),
      .acc_o(acc_q[i]),
      .ov_o(ov_now[i])
    );
  end

  assign bytes_acc = acc_q[ACC_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_q        <= 1'b0;
      ov_shadow_q <= 1'b0;
      for (int i = 0; i < NUM_ACC; i++) shadow_q[i] <= '0;
    end else begin
      ov_q <= (snap_i ? 1'b0 : ov_q) | (|ov_now);
      if (snap_i) begin
        ov_shadow_q <= ov_q;
        for (int i = 0; i < NUM_ACC; i++) shadow_q[i] <= acc_q[i];
      end
    end
  end

  logic [ACC_W-1:0] rd_tab [NUM_REG];
  always_comb begin
    for (int i = 0; i < NUM_REG; i++) rd_tab[i] = '0;
    for (int i = 0; i < NUM_ACC; i++) rd_tab[i] = shadow_q[i];
    rd_tab[ADDR_STAT] = {{(ACC_W-1){1'b0}}, ov_shadow_q};
  end
  assign reg_rdata_o = rd_tab[reg_addr_i];
endmodule

// File: rtl/prof_chk.sv
module prof_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             snap_i,
  input logic [2:0]       reg_addr_i,
  input logic [ACC_W-1:0] reg_rdata_o,
  input logic             b_valid_i,
  input logic             b_ready_i,
  input logic             r_valid_i,
  input logic             r_ready_i,
  input logic             r_last_i,
  input logic             wr_done,
  input logic             rd_done,
  input logic [ACC_W-1:0] wr_lat1,
  input logic [ACC_W-1:0] rd_lat1,
  input logic [ACC_W-1:0] bytes_acc,
  input logic             ov_q
);
  p_rdata_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> ($stable(reg_addr_i) -> $stable(reg_rdata_o)));

  p_addr7_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 3'd7) |-> (reg_rdata_o == '0));

  p_ov_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snap_i && ov_q) |=> ov_q);

  p_bytes_mono_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> (bytes_acc >= $past(bytes_acc)));

  p_wr_done_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done |-> (b_valid_i && b_ready_i));

  p_rd_done_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done |-> (r_valid_i && r_ready_i && r_last_i));

  p_lat1_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_done || rd_done) |-> ((wr_done ? wr_lat1 : rd_lat1) != '0));
endmodule

bind axi_burst_prof prof_chk #(.ACC_W(ACC_W)) u_prof_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .snap_i(snap_i),
  .reg_addr_i(reg_addr_i),
  .reg_rdata_o(reg_rdata_o),
  .b_valid_i(b_valid_i),
  .b_ready_i(b_ready_i),
  .r_valid_i(r_valid_i),
  .r_ready_i(r_ready_i),
  .r_last_i(r_last_i),
  .wr_done(wr_done),
  .rd_done(rd_done),
  .wr_lat1(wr_lat1),
  .rd_lat1(rd_lat1),
  .bytes_acc(bytes_acc),
  .ov_q(ov_q)
);

// File: tb/tb_axi_burst_prof.sv
`timescale 1ns/1ps
module tb_axi_burst_prof;
  localparam int W   = 8;
  localparam int MAX = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready;
  logic ar_valid, ar_ready, r_valid, r_ready, r_last, snap;
  logic [2:0] aw_size, ar_size, reg_addr;
  logic [W-1:0] rdata;

  int checks = 0;
  int failures = 0;
  int exp_v [8];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  axi_burst_prof #(.ACC_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .aw_valid_i(aw_valid), .aw_ready_i(aw_ready), .aw_size_i(aw_size),
    .w_valid_i(w_valid), .w_ready_i(w_ready), .w_last_i(w_last),
    .b_valid_i(b_valid), .b_ready_i(b_ready),
    .ar_valid_i(ar_valid), .ar_ready_i(ar_ready), .ar_size_i(ar_size),
    .r_valid_i(r_valid), .r_ready_i(r_ready), .r_last_i(r_last),
    .snap_i(snap), .reg_addr_i(reg_addr), .reg_rdata_o(rdata)
  );

  function automatic string req_of(int a);
    case (a)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R4";
      6: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic void clear_exp();
    for (int i = 0; i < 8; i++) exp_v[i] = 0;
  endfunction

  function automatic void add(int idx, int v);
    exp_v[idx] += v;
    if (exp_v[idx] > MAX) begin
      exp_v[idx] = MAX;
      exp_v[6] = 1;
    end
  endfunction

  task automatic check_regs(string ctx);
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a);
      #0.2;
      checks++;
      if (int'(rdata) != exp_v[a]) begin
        failures++;
        $display("FAIL %s %s addr=%0d actual=%0d expected=%0d",
                 req_of(a), ctx, a, rdata, exp_v[a]);
      end
    end
  endtask

  task automatic do_snap_check(string ctx);
    snap = 1'b1;
    @(negedge clk);
    snap = 1'b0;
    check_regs(ctx);
    @(negedge clk);
  endtask

  task automatic run_burst(bit is_wr, int sz, int beats, int g1, int g3);
    if (is_wr) begin aw_valid = 1; aw_ready = 1; aw_size = 3'(sz); end
    else       begin ar_valid = 1; ar_ready = 1; ar_size = 3'(sz); end
    @(negedge clk);
    aw_valid = 0; aw_ready = 0; ar_valid = 0; ar_ready = 0;
    for (int k = 1; k < g1; k++) begin
      if (is_wr) begin w_valid = 1; w_ready = 0; end
      else       begin r_valid = 1; r_ready = 0; end
      @(negedge clk);
    end
    for (int b = 0; b < beats; b++) begin
      if (is_wr) begin w_valid = 1; w_ready = 1; w_last = (b == beats - 1); end
      else       begin r_valid = 1; r_ready = 1; r_last = (b == beats - 1); end
      @(negedge clk);
    end
    w_valid = 0; w_ready = 0; w_last = 0; r_valid = 0; r_ready = 0; r_last = 0;
    if (is_wr) begin
      for (int k = 1; k < g3; k++) begin
        b_valid = 1; b_ready = 0;
        @(negedge clk);
      end
      b_valid = 1; b_ready = 1;
      @(negedge clk);
      b_valid = 0; b_ready = 0;
    end
    add(0, beats << sz);
    add(1, 1);
    add(2, g1);
    add(3, beats - 1);
    add(4, is_wr ? g3 : 0);
    add(5, 1);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    {aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready} = '0;
    {ar_valid, ar_ready, r_valid, r_ready, r_last, snap} = '0;
    aw_size = '0; ar_size = '0; reg_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state visible before any snapshot
    clear_exp();
    check_regs("R1 reset");

    // R2 R3 R4 R5 R6 R7 R10: write sweep with stalls
    for (int sz = 0; sz < 3; sz++)
      for (int bt = 1; bt <= 3; bt++)
        for (int g1 = 1; g1 <= 3; g1++)
          for (int g3 = 1; g3 <= 2; g3++) begin
            clear_exp();
            run_burst(1'b1, sz, bt, g1, g3);
            do_snap_check("write sweep");
          end

    // R2 R4 R5 R6 R7: read sweep, phase three stays zero
    for (int sz = 0; sz < 3; sz++)
      for (int bt = 1; bt <= 3; bt++)
        for (int g1 = 1; g1 <= 3; g1++) begin
          clear_exp();
          run_burst(1'b0, sz, bt, g1, 1);
          do_snap_check("read sweep");
        end

    // R10: valids without readies on every channel
    clear_exp();
    aw_valid = 1; ar_valid = 1; w_valid = 1; r_valid = 1; b_valid = 1; r_last = 1; w_last = 1;
    repeat (4) @(negedge clk);
    {aw_valid, ar_valid, w_valid, r_valid, b_valid, r_last, w_last} = '0;
    do_snap_check("R10 no handshake");

    // R3 R4: both directions in parallel
    clear_exp();
    aw_valid = 1; aw_ready = 1; aw_size = 3'd2;
    ar_valid = 1; ar_ready = 1; ar_size = 3'd0;
    @(negedge clk);
    {aw_valid, aw_ready, ar_valid, ar_ready} = '0;
    w_valid = 1; w_ready = 1; w_last = 1;
    r_valid = 1; r_ready = 1; r_last = 1;
    @(negedge clk);
    {w_valid, w_ready, w_last, r_valid, r_ready, r_last} = '0;
    b_valid = 1; b_ready = 1;
    @(negedge clk);
    b_valid = 0; b_ready = 0;
    exp_v[0] = 5; exp_v[1] = 2; exp_v[2] = 2; exp_v[3] = 0; exp_v[4] = 1; exp_v[5] = 2;
    do_snap_check("R3 dual channel");

    // R8: snapshot on the final read beat
    clear_exp();
    ar_valid = 1; ar_ready = 1; ar_size = 3'd1;
    @(negedge clk);
    ar_valid = 0; ar_ready = 0;
    r_valid = 1; r_ready = 1; r_last = 0;
    @(negedge clk);
    r_last = 1; snap = 1;
    @(negedge clk);
    {r_valid, r_ready, r_last, snap} = '0;
    exp_v[0] = 2; exp_v[1] = 1;
    check_regs("R8 old interval");
    @(negedge clk);
    clear_exp();
    exp_v[0] = 2; exp_v[2] = 1; exp_v[3] = 1; exp_v[5] = 1;
    do_snap_check("R8 new interval");

    // R9: saturation of the byte sum, then a clean interval
    clear_exp();
    run_burst(1'b0, 7, 2, 1, 1);
    do_snap_check("R9 saturate");
    clear_exp();
    do_snap_check("R9 cleared");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule